// File: doc/BRIEF.md
# 64-bit Interval Timer

A memory-mapped up-counter with a programmable 64-bit period. Software sees it through a 32-bit register port with single-cycle read and write strobes. The counter advances on a prescaled tick. The tick comes either from the bus clock or from an external strobe that is already synchronised to the bus clock. A mode bit picks the source, and a 4-bit prescaler field divides the selected tick by 1 to 16.

In continuous mode the count wraps to zero each time it reaches the period, and a pending flag is raised on every wrap. In one-shot mode the flag is raised once and the counter then stops, holding its last value. The pending flag is cleared by reading it, and the interrupt output is the pending flag gated by its enable.

Reading the 64-bit count takes two word reads. Reading the low word captures the high word at the same moment, so the two halves always belong together. The period is also written as two words. The high word waits in a holding register until the low word arrives, and then both halves take effect at once. A period of all ones with the interrupt disabled turns the block into a free-running timestamp counter.

Top module: `ivl_timer64`

## Requirements
- R1: After reset the counter is stopped, irq is low, and the status register, the mode register and the count low word all read 0.
- R2: Writing control with bit 0 set (offset 0x00) clears the count and starts it. With the bus clock as source, the status flag (status bit 0, offset 0x1C) first sets (P+1)·(D+1) clock cycles after the start write, where P is the period and D is the prescaler field in mode bits 11:8.
- R3: In continuous mode (mode bit 0 = 1, offset 0x04) the count returns to 0 on reaching the period, and the flag sets again every (P+1)·(D+1) ticks.
- R4: In one-shot mode (mode bit 0 = 0) the flag sets once. After that the counter stops and holds the value P, and no further flag is raised.
- R5: With mode bit 3 = 1 the counter advances only on cycles where ext_tick is high, so the first flag comes on the (P+1)·(D+1)-th strobe after start.
- R6: A write to the period high word (0x0C) changes nothing until the period low word (0x08) is written. At that point the held high word and the new low word become the active period together. Reading 0x0C returns the held high word.
- R7: Reading status returns the pending flag and clears it. A period match in the same cycle as the read leaves the flag set.
- R8: irq is high exactly when the status flag and enable bit 0 (offset 0x10) are both 1. The flag sets on a match even while the enable is 0.
- R9: Reading the count low word (0x20) captures the high half of the same count value. A later read of 0x24 returns that captured half, even after the counter has carried into the high half.
- R10: Writing control with bit 8 set stops the counter and clears the count, the prescaler phase and the status flag. Bit 8 wins over bit 0 when both are written in one cycle.
- R11: The mode register reads back bits 0, 3 and 11:8, and the enable register reads back bit 0. All other bits, and unmapped offsets, read 0.
- R12: Writes to the status and count registers are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | 6 | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after rd_en |
| ext_tick | input | 1 | Synchronised alternate tick strobe |
| irq | output | 1 | Period interrupt |

## Verification
The bench builds the timer with DATA_W = 16, which makes the count 32 bits wide. The carry from the low word into the high word then happens after 65536 ticks, about a third of the cycle budget. The coherence check can therefore take a low-word read just before that carry and a high-word read just after it. Short periods of 2 to 5, combined with prescaler values of 0, 1, 3 and 15, keep the continuous and one-shot timing checks to a few dozen cycles each.

// File: rtl/ivl_timer64.sv
module ivl_timer64 #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [5:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ext_tick,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;
  localparam logic [5:0] A_CTL  = 6'h00;
  localparam logic [5:0] A_MODE = 6'h04;
  localparam logic [5:0] A_PLO  = 6'h08;
  localparam logic [5:0] A_PHI  = 6'h0C;
  localparam logic [5:0] A_IEN  = 6'h10;
  localparam logic [5:0] A_STS  = 6'h1C;
  localparam logic [5:0] A_CLO  = 6'h20;
  localparam logic [5:0] A_CHI  = 6'h24;

  logic              running;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  period;
  logic [DATA_W-1:0] per_hi_hold;
  logic [DATA_W-1:0] cnt_hi_snap;
  logic              mode_cont;
  logic              mode_alt;
  logic [3:0]        presc;
  logic [3:0]        pre_cnt;
  logic              ien;
  logic              sts;
  logic [DATA_W-1:0] mode_rd;

  wire wr_ctl   = wr_en && (addr == A_CTL);
  wire do_rst   = wr_ctl && wdata[8];
  wire do_start = wr_ctl && wdata[0];
  wire tick     = running && (mode_alt ? ext_tick : 1'b1);
  wire adv      = tick && (pre_cnt == presc);
  wire hit      = adv && (cnt == period);
  wire rd_sts   = rd_en && (addr == A_STS);

  assign irq = sts & ien;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      pre_cnt <= '0;
    end else if (do_rst) begin
      running <= 1'b0;
      cnt     <= '0;
      pre_cnt <= '0;
    end else if (do_start) begin
      running <= 1'b1;
      cnt     <= '0;
      pre_cnt <= '0;
    end else if (tick) begin
      pre_cnt <= adv ? 4'd0 : pre_cnt + 4'd1;
      if (hit) begin
        if (mode_cont) cnt <= '0;
        else           running <= 1'b0;
      end else if (adv) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      sts <= 1'b0;
    else if (do_rst) sts <= 1'b0;
    else if (hit)    sts <= 1'b1;
    else if (rd_sts) sts <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_cont   <= 1'b0;
      mode_alt    <= 1'b0;
      presc       <= '0;
      ien         <= 1'b0;
      per_hi_hold <= '0;
      period      <= '1;
    end else if (wr_en) begin
      case (addr)
        A_MODE: begin
          mode_cont <= wdata[0];
          mode_alt  <= wdata[3];
          presc     <= wdata[11:8];
        end
        A_IEN: ien         <= wdata[0];
        A_PHI: per_hi_hold <= wdata;
        A_PLO: period      <= {per_hi_hold, wdata};
        default: ;
      endcase
    end
  end

  always_comb begin
    mode_rd       = '0;
    mode_rd[0]    = mode_cont;
    mode_rd[3]    = mode_alt;
    mode_rd[11:8] = presc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata       <= '0;
      cnt_hi_snap <= '0;
    end else if (rd_en) begin
      case (addr)
        A_MODE: rdata <= mode_rd;
        A_PLO:  rdata <= period[DATA_W-1:0];
        A_PHI:  rdata <= per_hi_hold;
        A_IEN:  rdata <= DATA_W'(ien);
        A_STS:  rdata <= DATA_W'(sts);
        A_CLO: begin
          rdata       <= cnt[DATA_W-1:0];
          cnt_hi_snap <= cnt[CNT_W-1:DATA_W];
        end
        A_CHI:  rdata <= cnt_hi_snap;
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ivl_timer64_chk.sv
module ivl_timer64_chk #(
  parameter int DATA_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic [5:0]            addr,
  input logic [DATA_W-1:0]     wdata,
  input logic                  running,
  input logic                  mode_cont,
  input logic                  sts,
  input logic [2*DATA_W-1:0]   cnt,
  input logic [2*DATA_W-1:0]   period
);
  localparam int CNT_W = 2 * DATA_W;
  logic ctl_w;
  assign ctl_w = wr_en && (addr == 6'h00);

  AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && wdata[8]) |=> (!running && cnt == '0 && !sts)); // R10
  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && wdata[0] && !wdata[8]) |=> (running && cnt == '0)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !ctl_w && cnt != period) |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1))); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (running && mode_cont && !ctl_w && cnt == period) |=> (cnt == '0 || cnt == $past(cnt))); // R3
  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !ctl_w) |=> (!running && $stable(cnt))); // R4
  AST_HIGH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 6'h0C) |=> $stable(period)); // R6
  AST_STS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 6'h1C && !(running && cnt == period)) |=> !sts); // R7
endmodule

bind ivl_timer64 ivl_timer64_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .running(running), .mode_cont(mode_cont), .sts(sts),
  .cnt(cnt), .period(period)
);

// File: tb/ivl_timer64_tb.sv
module ivl_timer64_tb_top;
  localparam int DW = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [5:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic ext_tick = 1'b0;
  logic irq;

  int nchk = 0, nfail = 0;
  int cyc = 0, strobes = 0;
  int c0 = 0, s0 = 0, elapsed = 0, wr_cyc = 0, rd_cyc = 0;
  bit strobe_on = 1'b0;
  logic [DW-1:0] rv;

  ivl_timer64 #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ext_tick(ext_tick), .irq(irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ext_tick) strobes <= strobes + 1;
  end

  initial begin
    forever begin
      @(negedge clk);
      ext_tick = strobe_on && (cyc % 3 == 2);
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0; wr_cyc = cyc;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [DW-1:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0; d = rdata; rd_cyc = cyc;
  endtask

  task automatic cfg(input bit cont, input bit alt, input int pre,
                     input logic [DW-1:0] phi, input logic [DW-1:0] plo, input bit en);
    bus_wr(6'h00, 16'h0100);
    bus_wr(6'h04, DW'((pre << 8) | (int'(alt) << 3) | int'(cont)));
    bus_wr(6'h0C, phi);
    bus_wr(6'h08, plo);
    bus_wr(6'h10, DW'(en));
    bus_wr(6'h00, 16'h0001);
    c0 = wr_cyc; s0 = strobes;
  endtask

  task automatic wait_irq(input int maxc);
    for (int k = 0; k < maxc && !irq; k++) @(negedge clk);
    elapsed = cyc - c0;
  endtask

  task automatic t_reset;
    chk("R1 irq", irq, 0);
    bus_rd(6'h1C, rv); chk("R1 status", rv, 0);
    bus_rd(6'h04, rv); chk("R1 mode", rv, 0);
    bus_rd(6'h20, rv); chk("R1 count", rv, 0);
  endtask

  task automatic t_cont(input int pre, input int p);
    int t = (p + 1) * (pre + 1);
    cfg(1, 0, pre, 0, DW'(p), 1);
    wait_irq(4 * t);
    chk("R2 first flag time", elapsed, t);
    bus_rd(6'h1C, rv); chk("R7 status read", rv, 1);
    chk("R7 cleared irq", irq, 0);
    wait_irq(4 * t);
    chk("R3 second flag time", elapsed, 2 * t);
  endtask

  task automatic t_oneshot(input int pre, input int p);
    int t = (p + 1) * (pre + 1);
    cfg(0, 0, pre, 0, DW'(p), 1);
    wait_irq(4 * t);
    chk("R4 flag time", elapsed, t);
    bus_rd(6'h1C, rv); chk("R4 status", rv, 1);
    wait_irq(3 * t);
    chk("R4 no second flag", irq, 0);
    bus_rd(6'h20, rv); chk("R4 count holds", rv, p);
    bus_wr(6'h20, 16'h0000);
    bus_wr(6'h24, 16'h1234);
    bus_rd(6'h20, rv); chk("R12 count write ignored", rv, p);
    bus_wr(6'h1C, 16'h0001);
    chk("R12 status write irq", irq, 0);
    bus_rd(6'h1C, rv); chk("R12 status write ignored", rv, 0);
  endtask

  task automatic t_alt;
    strobe_on = 1'b1;
    cfg(1, 1, 1, 0, 16'd2, 1);
    wait_irq(200);
    chk("R5 strobe count at flag", strobes - s0, 6);
    chk("R5 slower than clock", elapsed >= 12, 1);
    strobe_on = 1'b0;
  endtask

  task automatic t_enable;
    cfg(0, 0, 0, 0, 16'd3, 0);
    repeat (12) @(negedge clk);
    chk("R8 irq masked", irq, 0);
    bus_wr(6'h10, 16'h0001);
    chk("R8 irq on enable", irq, 1);
    bus_rd(6'h1C, rv); chk("R8 status set while masked", rv, 1);
    chk("R8 irq after clear", irq, 0);
  endtask

  task automatic t_stage;
    cfg(0, 0, 0, 0, 16'd5, 1);
    wait_irq(40); chk("R6 base period", elapsed, 6);
    bus_wr(6'h0C, 16'h0001);
    bus_wr(6'h00, 16'h0100);
    bus_wr(6'h00, 16'h0001); c0 = wr_cyc;
    wait_irq(40); chk("R6 high held back", elapsed, 6);
    bus_rd(6'h0C, rv); chk("R6 held high reads", rv, 1);
    bus_wr(6'h08, 16'h0005);
    bus_wr(6'h00, 16'h0100);
    bus_wr(6'h00, 16'h0001); c0 = wr_cyc;
    repeat (30) @(negedge clk);
    chk("R6 new period active", irq, 0);
  endtask

  task automatic t_swrst;
    cfg(1, 0, 0, 0, 16'd3, 1);
    wait_irq(40);
    chk("R10 pending before reset", irq, 1);
    bus_wr(6'h00, 16'h0101);
    chk("R10 irq cleared", irq, 0);
    bus_rd(6'h20, rv); chk("R10 count cleared", rv, 0);
    repeat (10) @(negedge clk);
    bus_rd(6'h20, rv); chk("R10 stays stopped", rv, 0);
    bus_rd(6'h1C, rv); chk("R10 status cleared", rv, 0);
  endtask

  task automatic t_regs;
    bus_wr(6'h04, 16'hFFFF);
    bus_rd(6'h04, rv); chk("R11 mode readback", rv, 16'h0F09);
    bus_wr(6'h10, 16'hFFFF);
    bus_rd(6'h10, rv); chk("R11 enable readback", rv, 1);
    bus_rd(6'h14, rv); chk("R11 unmapped", rv, 0);
    bus_wr(6'h10, 16'h0000);
  endtask

  task automatic t_coherent;
    logic [31:0] e;
    logic [DW-1:0] lo;
    cfg(1, 0, 0, 16'hFFFF, 16'hFFFF, 0);
    repeat (65520) @(negedge clk);
    bus_rd(6'h20, lo); e = 32'(rd_cyc - c0 - 1);
    chk("R9 low before carry", lo, e[15:0]);
    repeat (30) @(negedge clk);
    bus_rd(6'h24, rv);
    chk("R9 high captured with low", rv, e[31:16]);
    bus_rd(6'h20, lo); e = 32'(rd_cyc - c0 - 1);
    bus_rd(6'h24, rv);
    chk("R9 high after carry", {rv, lo}, e);
    chk("R9 carry reached", e[31:16], 1);
    bus_wr(6'h00, 16'h0100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_regs;
    t_cont(0, 5);
    t_cont(3, 4);
    t_cont(15, 2);
    t_oneshot(0, 4);
    t_oneshot(1, 3);
    t_alt;
    t_enable;
    t_stage;
    t_swrst;
    t_coherent;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule